// File: doc/BRIEF.md
# Single-data-rate SDRAM controller with periodic refresh

This block sits between a simple host request port and a four-bank SDRAM array 64 bits wide. It brings the memory up after reset, turns each host read or write into a row activation followed by a column access with auto precharge, and inserts auto refresh commands at a fixed rate. A host presents one access at a time with `req_i`. The access names a bank, a row, a column, write data and a byte mask. The host holds the request until `ack_o` pulses. Read data comes back later with a one-cycle `rd_valid_o` strobe.

All DRAM timing is held as clock counts. The nanosecond minima and the clock period are parameters, and each count is rounded up to whole cycles: 3 for activate-to-column, 3 for precharge, 6 for active time and 9 for row cycle at 7.5 ns. Every access closes its row through auto precharge, so the controller never tracks open pages. A refresh that is due always wins over a waiting host request.

Top module: `sdram_ctrl`

## Requirements
- R1: While `rst_ni` is low, CKE is high, the command pins show no-op, and `ack_o`, `rd_valid_o` and `sd_dq_oe_o` are low.
- R2: After reset release, the first command is a precharge with A10 high, on the INIT_CYCLES-th clock. Next come INIT_REFS auto refreshes, the first 3 cycles after the precharge and then one every 9 cycles. Nine cycles after the last refresh comes a mode register load with BA=00 and A=0x030, which sets burst length 1, sequential order and CAS latency 3. No command follows within 2 cycles of the mode register load.
- R3: Commands are encoded on {CS#,RAS#,CAS#,WE#} as follows. Activate is 0011, read 0101, write 0100, precharge 0010, auto refresh 0001, mode register load 0000 and no-op 0111.
- R4: An activate puts the row on A11..A0 and the bank on BA (BA1 = bank bit 1, BA0 = bank bit 0). The read or write follows exactly 3 cycles later to the same bank, with the column on A8..A0 and A10 high.
- R5: A write drives the data with `sd_dq_oe_o` high in the same cycle as the write command. DQM bit i high blocks byte i (DQ[8i+7:8i]) in that cycle.
- R6: A read command carries DQM low and `sd_dq_oe_o` low. The controller samples `sd_dq_i` at the third rising edge after the edge that samples the read command. `rd_valid_o` is high for that single following cycle, with the data on `rd_data_o`.
- R7: No command follows a read or write within 6 cycles. Two activates are at least 9 cycles apart.
- R8: `ack_o` is a one-cycle pulse in the cycle the read or write command is on the pins. There is exactly one pulse per accepted request.
- R9: After each auto refresh, no activate or refresh follows for 9 cycles. During normal operation a refresh is issued once every REF_INTERVAL cycles on average.
- R10: A due refresh takes priority over a host request. Even with `req_i` held high continuously, consecutive refreshes are at most REF_INTERVAL+10 and at least REF_INTERVAL-10 cycles apart.
- R11: On a write, a masked byte (mask bit i = 1) leaves the stored byte unchanged. An all-ones mask changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, held until ack |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_bank_i | input | 2 | Bank |
| req_row_i | input | 12 | Row |
| req_col_i | input | 9 | Column |
| req_wdata_i | input | 64 | Write data |
| req_wmask_i | input | 8 | Byte mask, 1 = byte not written |
| ack_o | output | 1 | Request accepted (column command issued) |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 64 | Read data |
| sd_cke_o | output | 1 | Clock enable |
| sd_cs_no | output | 1 | Chip select, active low |
| sd_ras_no | output | 1 | Row strobe, active low |
| sd_cas_no | output | 1 | Column strobe, active low |
| sd_we_no | output | 1 | Write enable, active low |
| sd_addr_o | output | 12 | Multiplexed address |
| sd_ba_o | output | 2 | Bank address |
| sd_dqm_o | output | 8 | Byte data mask |
| sd_dq_o | output | 64 | Write data to the array |
| sd_dq_oe_o | output | 1 | Data output enable |
| sd_dq_i | input | 64 | Read data from the array |

## Verification
The bench holds `req_i` high across back-to-back accesses while refreshes fall due. A controller that served the host first would starve refresh, and the gap between refreshes would grow without bound. The bench measures every command interval against the rounded cycle counts, so a counter that is off by one shows up as a 2-cycle activate-to-column gap or a shortened recovery after auto precharge. Partially and fully masked writes are read back next to an untouched neighbouring column, a different row in the same bank and the same row in another bank. A wrong mask polarity, a dropped A10 or a bank mix-up therefore returns wrong data. The read data is sampled exactly at the CAS-latency edge, so a capture pipeline one stage short or long returns the wrong word.

// File: rtl/sdram_ctrl_pkg.sv
package sdram_ctrl_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_POWERUP,
    ST_INIT_REF,
    ST_MODE,
    ST_IDLE,
    ST_ACCESS
  } ctrl_state_e;

  function automatic int ps_to_cyc(int t_ps, int clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int INTERVAL = 2080
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_ack_i,
  output logic ref_pend_o
);
  localparam int CW = $clog2(INTERVAL + 1);

  logic [CW-1:0] tick_q;
  logic          pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= CW'(INTERVAL - 1);
      pend_q <= 1'b0;
    end else begin
      if (tick_q == '0) tick_q <= CW'(INTERVAL - 1);
      else              tick_q <= tick_q - 1'b1;
      if (tick_q == '0)   pend_q <= 1'b1;
      else if (ref_ack_i) pend_q <= 1'b0;
    end
  end

  assign ref_pend_o = pend_q;

  // pending only clears when the sequencer takes it
  assert_pend_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ref_pend_o) |-> $past(ref_ack_i));

endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
  parameter int CL   = 3,
  parameter int DQ_W = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rd_issue_i,
  input  logic [DQ_W-1:0] dq_i,
  output logic            rd_valid_o,
  output logic [DQ_W-1:0] rd_data_o
);
  logic [CL-1:0]   pipe_q;
  logic            valid_q;
  logic [DQ_W-1:0] data_q;

  // rd_issue_i follows the pin register; stage 0 marks the array's sampling edge
  generate
    if (CL == 1) begin : g_cl1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= rd_issue_i;
      end
    end else begin : g_cln
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q[CL-2:0], rd_issue_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= pipe_q[CL-1];
      if (pipe_q[CL-1]) data_q <= dq_i;
    end
  end

  assign rd_valid_o = valid_q;
  assign rd_data_o  = data_q;

  assert_valid_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);

endmodule

// File: rtl/sdram_ctrl.sv
module sdram_ctrl
  import sdram_ctrl_pkg::*;
#(
  parameter int CLK_PS       = 7500,
  parameter int T_RCD_PS     = 20000,
  parameter int T_RP_PS      = 20000,
  parameter int T_RAS_PS     = 45000,
  parameter int T_RC_PS      = 65000,
  parameter int T_WR_CYC     = 2,
  parameter int T_MRD_CYC    = 2,
  parameter int CAS_LAT      = 3,
  parameter int INIT_CYCLES  = 26667,
  parameter int INIT_REFS    = 8,
  parameter int REF_INTERVAL = 2080,
  parameter int ROW_W        = 12,
  parameter int COL_W        = 9,
  parameter int BANK_W       = 2,
  parameter int DQ_W         = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [DQ_W-1:0]   req_wdata_i,
  input  logic [DQ_W/8-1:0] req_wmask_i,
  output logic              ack_o,
  output logic              rd_valid_o,
  output logic [DQ_W-1:0]   rd_data_o,
  output logic              sd_cke_o,
  output logic              sd_cs_no,
  output logic              sd_ras_no,
  output logic              sd_cas_no,
  output logic              sd_we_no,
  output logic [ROW_W-1:0]  sd_addr_o,
  output logic [BANK_W-1:0] sd_ba_o,
  output logic [DQ_W/8-1:0] sd_dqm_o,
  output logic [DQ_W-1:0]   sd_dq_o,
  output logic              sd_dq_oe_o,
  input  logic [DQ_W-1:0]   sd_dq_i
);
  localparam int BYTES   = DQ_W / 8;
  localparam int TRCD    = ps_to_cyc(T_RCD_PS, CLK_PS);
  localparam int TRP     = ps_to_cyc(T_RP_PS, CLK_PS);
  localparam int TRAS    = ps_to_cyc(T_RAS_PS, CLK_PS);
  localparam int TRC     = ps_to_cyc(T_RC_PS, CLK_PS);
  // column command to next command, auto precharge included
  localparam int GAP     = max3(TRC - TRCD, T_WR_CYC + TRP, TRAS + TRP - TRCD);
  localparam int CNT_MAX = max3(INIT_CYCLES, TRC, GAP);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int RFW     = $clog2(INIT_REFS + 1);
  localparam int AP_BIT  = 10;
  // burst length 1, sequential, CAS latency in bits 6:4
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);
  localparam logic [ROW_W-1:0] AP_MASK   = ROW_W'(1) << AP_BIT;

  ctrl_state_e       state_q;
  sd_cmd_e           cmd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [RFW-1:0]    refs_left_q;
  logic [ROW_W-1:0]  addr_q;
  logic [BANK_W-1:0] ba_q;
  logic [BYTES-1:0]  dqm_q;
  logic [DQ_W-1:0]   dq_q;
  logic              oe_q;
  logic              ack_q;
  logic              we_q;
  logic [COL_W-1:0]  col_q;
  logic [DQ_W-1:0]   wdata_q;
  logic [BYTES-1:0]  wmask_q;
  logic              ref_pend;
  logic              ref_take;

  assign ref_take = (state_q == ST_IDLE) && (cnt_q == '0) && ref_pend;

  sdram_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_ref_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_ack_i  (ref_take),
    .ref_pend_o (ref_pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_POWERUP;
      cnt_q       <= CNT_W'(INIT_CYCLES - 1);
      cmd_q       <= CMD_NOP;
      refs_left_q <= '0;
      addr_q      <= '0;
      ba_q        <= '0;
      dqm_q       <= '0;
      dq_q        <= '0;
      oe_q        <= 1'b0;
      ack_q       <= 1'b0;
      we_q        <= 1'b0;
      col_q       <= '0;
      wdata_q     <= '0;
      wmask_q     <= '0;
    end else begin
      cmd_q <= CMD_NOP;
      oe_q  <= 1'b0;
      ack_q <= 1'b0;
      dqm_q <= '0;
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else begin
        unique case (state_q)
          ST_POWERUP: begin
            cmd_q       <= CMD_PRE;
            addr_q      <= AP_MASK;
            cnt_q       <= CNT_W'(TRP - 1);
            refs_left_q <= RFW'(INIT_REFS);
            state_q     <= ST_INIT_REF;
          end
          ST_INIT_REF: begin
            cmd_q       <= CMD_REF;
            cnt_q       <= CNT_W'(TRC - 1);
            refs_left_q <= refs_left_q - 1'b1;
            if (refs_left_q == RFW'(1)) state_q <= ST_MODE;
          end
          ST_MODE: begin
            cmd_q   <= CMD_MRS;
            addr_q  <= MODE_WORD;
            ba_q    <= '0;
            cnt_q   <= CNT_W'(T_MRD_CYC - 1);
            state_q <= ST_IDLE;
          end
          ST_IDLE: begin
            if (ref_pend) begin
              cmd_q <= CMD_REF;
              cnt_q <= CNT_W'(TRC - 1);
            end else if (req_i) begin
              cmd_q   <= CMD_ACT;
              addr_q  <= req_row_i;
              ba_q    <= req_bank_i;
              we_q    <= req_we_i;
              col_q   <= req_col_i;
              wdata_q <= req_wdata_i;
              wmask_q <= req_wmask_i;
              cnt_q   <= CNT_W'(TRCD - 1);
              state_q <= ST_ACCESS;
            end
          end
          ST_ACCESS: begin
            cmd_q   <= we_q ? CMD_WR : CMD_RD;
            addr_q  <= ROW_W'(col_q) | AP_MASK;
            ack_q   <= 1'b1;
            cnt_q   <= CNT_W'(GAP - 1);
            state_q <= ST_IDLE;
            if (we_q) begin
              oe_q  <= 1'b1;
              dq_q  <= wdata_q;
              dqm_q <= wmask_q;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  sdram_rd_capture #(.CL(CAS_LAT), .DQ_W(DQ_W)) u_rd_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_issue_i (cmd_q == CMD_RD),
    .dq_i       (sd_dq_i),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o)
  );

  assign {sd_cs_no, sd_ras_no, sd_cas_no, sd_we_no} = cmd_q;
  assign sd_cke_o   = 1'b1;
  assign sd_addr_o  = addr_q;
  assign sd_ba_o    = ba_q;
  assign sd_dqm_o   = dqm_q;
  assign sd_dq_o    = dq_q;
  assign sd_dq_oe_o = oe_q;
  assign ack_o      = ack_q;

  assert_col_after_act_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> $past(cmd_q, 3) == CMD_ACT);

  assert_col_autoprecharge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> sd_addr_o[AP_BIT]);

  assert_rd_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(cmd_q, CAS_LAT + 1) == CMD_RD);

  assert_ack_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  assert_ref_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_REF) |=> (cmd_q == CMD_NOP));

endmodule

// File: tb/sdram_ctrl_bench.sv
module sdram_ctrl_bench;
  localparam int INIT_CYC = 40;
  localparam int REF_INT  = 120;
  localparam int NREFS    = 8;

  typedef struct packed {
    logic        we;
    logic [1:0]  bank;
    logic [11:0] row;
    logic [8:0]  col;
    logic [63:0] data;
    logic [7:0]  mask;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 12'h000, 9'h000, 64'h1111_2222_3333_4444, 8'h00},
    '{1'b1, 2'd1, 12'h123, 9'h045, 64'hA5A5_5A5A_C3C3_3C3C, 8'h00},
    '{1'b1, 2'd3, 12'hFFF, 9'h1FF, 64'hFEDC_BA98_7654_3210, 8'h00},
    '{1'b1, 2'd2, 12'h800, 9'h100, 64'h0123_4567_89AB_CDEF, 8'h00},
    '{1'b0, 2'd0, 12'h000, 9'h000, 64'h0, 8'h00},
    '{1'b0, 2'd3, 12'hFFF, 9'h1FF, 64'h0, 8'h00},
    '{1'b1, 2'd1, 12'h123, 9'h045, 64'hFFFF_FFFF_FFFF_FFFF, 8'hA5}, // R11 partial
    '{1'b0, 2'd1, 12'h123, 9'h045, 64'h0, 8'h00},
    '{1'b1, 2'd2, 12'h800, 9'h100, 64'h0, 8'hFF},                   // R11 all masked
    '{1'b0, 2'd2, 12'h800, 9'h100, 64'h0, 8'h00},
    '{1'b0, 2'd1, 12'h124, 9'h045, 64'h0, 8'h00},                   // other row
    '{1'b1, 2'd0, 12'h000, 9'h001, 64'h5555_6666_7777_8888, 8'h00},
    '{1'b1, 2'd1, 12'h000, 9'h000, 64'h9999_AAAA_BBBB_CCCC, 8'h00}, // other bank
    '{1'b0, 2'd0, 12'h000, 9'h001, 64'h0, 8'h00},
    '{1'b0, 2'd0, 12'h000, 9'h000, 64'h0, 8'h00},
    '{1'b0, 2'd1, 12'h000, 9'h000, 64'h0, 8'h00}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, req_we_i = 1'b0;
  logic [1:0]  req_bank_i = '0;
  logic [11:0] req_row_i = '0;
  logic [8:0]  req_col_i = '0;
  logic [63:0] req_wdata_i = '0;
  logic [7:0]  req_wmask_i = '0;
  logic        ack_o, rd_valid_o;
  logic [63:0] rd_data_o;
  logic        sd_cke_o, sd_cs_no, sd_ras_no, sd_cas_no, sd_we_no;
  logic [11:0] sd_addr_o;
  logic [1:0]  sd_ba_o;
  logic [7:0]  sd_dqm_o;
  logic [63:0] sd_dq_o;
  logic        sd_dq_oe_o;
  logic [63:0] sd_dq_i = '0;

  sdram_ctrl #(.INIT_CYCLES(INIT_CYC), .REF_INTERVAL(REF_INT), .INIT_REFS(NREFS)) u_sdram_ctrl (
    .clk_i, .rst_ni, .req_i, .req_we_i, .req_bank_i, .req_row_i, .req_col_i,
    .req_wdata_i, .req_wmask_i, .ack_o, .rd_valid_o, .rd_data_o,
    .sd_cke_o, .sd_cs_no, .sd_ras_no, .sd_cas_no, .sd_we_no, .sd_addr_o,
    .sd_ba_o, .sd_dqm_o, .sd_dq_o, .sd_dq_oe_o, .sd_dq_i
  );

  always #5 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // array model and reference shadow
  logic [63:0] model_mem [logic [22:0]];
  logic [63:0] shadow    [logic [22:0]];
  logic [11:0] open_row [4];
  logic [63:0] exp_q [$];
  int          rd_cyc_q [$];
  bit          pv [3];
  logic [63:0] pd [3];

  int cyc = 0;
  int last_act = -1000, last_rw = -1000, last_ref = -1000, last_mrs = -1000;
  int last_cmd = -1000, act_ba = 0;
  int init_refs = 0, post_refs = 0, acks = 0, reqs = 0;
  bit seen_pre = 0;

  always @(negedge clk_i) begin
    if (rst_ni) begin
      logic [3:0]  cmd;
      logic [22:0] key;
      logic [63:0] cur;
      cyc++;
      // read data path: drive the word for the CL=3 capture edge
      sd_dq_i = pv[2] ? pd[2] : 64'h0;
      pv[2] = pv[1]; pd[2] = pd[1];
      pv[1] = pv[0]; pd[1] = pd[0];
      pv[0] = 1'b0;  pd[0] = '0;
      cmd = {sd_cs_no, sd_ras_no, sd_cas_no, sd_we_no};
      case (cmd)
        4'b0010: begin // R3 precharge
          if (!seen_pre) begin
            check(cyc == INIT_CYC, "R2", "first precharge cycle", cyc, INIT_CYC);
            check(sd_addr_o[10], "R2", "precharge all A10", sd_addr_o[10], 1);
            seen_pre = 1;
          end
          last_cmd = cyc;
        end
        4'b0001: begin // R3 refresh
          if (init_refs < NREFS) begin
            check(cyc - last_cmd == ((init_refs == 0) ? 3 : 9), "R2", "init refresh spacing",
                  cyc - last_cmd, (init_refs == 0) ? 3 : 9);
            init_refs++;
          end else begin
            check(cyc - last_ref >= 9 && cyc - last_rw >= 6, "R9", "refresh spacing",
                  cyc - last_ref, 9);
            if (post_refs > 0)
              check(cyc - last_ref <= REF_INT + 10 && cyc - last_ref >= REF_INT - 10, "R10",
                    "refresh interval", cyc - last_ref, REF_INT);
            post_refs++;
          end
          last_ref = cyc; last_cmd = cyc;
        end
        4'b0000: begin // R3 mode register load
          check(init_refs == NREFS && cyc - last_ref == 9, "R2", "mode load placement",
                cyc - last_ref, 9);
          check(sd_addr_o == 12'h030 && sd_ba_o == 2'b00, "R2", "mode word", sd_addr_o, 12'h030);
          last_mrs = cyc; last_cmd = cyc;
        end
        4'b0011: begin // R3 activate
          check(cyc - last_mrs >= 2, "R2", "command after mode load", cyc - last_mrs, 2);
          check(cyc - last_act >= 9 && cyc - last_rw >= 6, "R7", "activate spacing",
                cyc - last_act, 9);
          check(cyc - last_ref >= 9, "R9", "activate after refresh", cyc - last_ref, 9);
          open_row[sd_ba_o] = sd_addr_o;
          act_ba = sd_ba_o;
          last_act = cyc; last_cmd = cyc;
        end
        4'b0100, 4'b0101: begin // R3 write / read
          check(cyc - last_act == 3 && sd_addr_o[10] && sd_ba_o == act_ba[1:0], "R4",
                "column command", cyc - last_act, 3);
          key = {sd_ba_o, open_row[sd_ba_o], sd_addr_o[8:0]};
          cur = model_mem.exists(key) ? model_mem[key] : 64'h0;
          if (cmd == 4'b0100) begin
            check(sd_dq_oe_o, "R5", "write drives data", sd_dq_oe_o, 1);
            for (int b = 0; b < 8; b++)
              if (!sd_dqm_o[b]) cur[8*b +: 8] = sd_dq_o[8*b +: 8];
            model_mem[key] = cur;
          end else begin
            check(sd_dqm_o == 8'h00 && !sd_dq_oe_o, "R6", "read dqm/oe", sd_dqm_o, 0);
            pv[0] = 1'b1; pd[0] = cur;
            rd_cyc_q.push_back(cyc);
          end
          last_rw = cyc; last_cmd = cyc;
        end
        default: ;
      endcase
      if (ack_o) begin
        acks++;
        check(cmd == 4'b0100 || cmd == 4'b0101, "R8", "ack with column command", cmd, 4'b0101);
      end
      if (rd_valid_o) begin
        int c0;
        logic [63:0] e;
        c0 = (rd_cyc_q.size() > 0) ? rd_cyc_q.pop_front() : -100;
        e  = (exp_q.size() > 0) ? exp_q.pop_front() : 64'hX;
        check(cyc - c0 == 4, "R6", "read latency", cyc - c0, 4);
        check(rd_data_o === e, "R6 R11", "read data", rd_data_o, e);
      end
    end
  end

  task automatic issue(vec_t v);
    logic [22:0] key;
    logic [63:0] cur;
    req_i = 1'b1; req_we_i = v.we; req_bank_i = v.bank; req_row_i = v.row;
    req_col_i = v.col; req_wdata_i = v.data; req_wmask_i = v.mask;
    key = {v.bank, v.row, v.col};
    cur = shadow.exists(key) ? shadow[key] : 64'h0;
    if (v.we) begin
      for (int b = 0; b < 8; b++)
        if (!v.mask[b]) cur[8*b +: 8] = v.data[8*b +: 8];
      shadow[key] = cur;
    end else begin
      exp_q.push_back(cur);
    end
    reqs++;
    do @(negedge clk_i); while (!ack_o);
  endtask

  task automatic check_reset(string tag);
    check(sd_cke_o && {sd_cs_no, sd_ras_no, sd_cas_no, sd_we_no} == 4'b0111, "R1",
          {tag, " cke/nop"}, {sd_cke_o, sd_cs_no, sd_ras_no, sd_cas_no, sd_we_no}, 5'b10111);
    check(!ack_o && !rd_valid_o && !sd_dq_oe_o, "R1", {tag, " strobes low"},
          {ack_o, rd_valid_o, sd_dq_oe_o}, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check_reset("in reset");
    #1 rst_ni = 1'b1;
    // table walk twice with req held high: refresh must still get through (R10)
    for (int pass = 0; pass < 2; pass++)
      for (int i = 0; i < NV; i++) issue(VECS[i]);
    req_i = 1'b0;
    repeat (400) @(negedge clk_i);
    check(exp_q.size() == 0, "R6", "reads outstanding", exp_q.size(), 0);
    check(acks == reqs, "R8", "ack count", acks, reqs);
    check(post_refs >= 4, "R9", "refresh count", post_refs, 4);
    check(init_refs == NREFS, "R2", "init refresh count", init_refs, NREFS);
    // asynchronous reset mid-run
    @(negedge clk_i);
    #2 rst_ni = 1'b0;
    #1 check_reset("async reset");
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    check(1'b0, "WATCHDOG", "run timed out", 0, 1);
    finish_run();
  end

endmodule